// File: doc/BRIEF.md
# Instruction Condition Code Evaluator

This block decides whether an instruction is allowed to take effect. It reads the 4-bit condition field held in the top nibble of a 32-bit instruction word and compares it against the four status flags: negative, zero, carry and overflow. The execute-enable output goes high when the condition holds. When it is low, the surrounding pipeline treats the instruction as a no-op. The check applies to every instruction class, not only to branches.

The block is purely combinational. All eight base predicates are evaluated in parallel from the flags. The upper three bits of the field pick one of them, and the lowest bit of the field inverts the chosen result. This gives all sixteen codes. Code 1110 always executes. Code 1111 never executes and raises a separate indicator, so that decode logic can route it to special handling.

Top module: `cond_gate`

## Requirements
- R1: The condition is read only from `instr_i[31:28]`. Bits 27:0 never change either output.
- R2: Code 0000 (equal) executes when Z=1. Code 0001 (not equal) executes when Z=0.
- R3: Code 0010 (carry set / unsigned higher-or-same) executes when C=1. Code 0011 executes when C=0.
- R4: Code 0100 (negative) executes when N=1. Code 0101 (positive or zero) executes when N=0.
- R5: Code 0110 (overflow) executes when V=1. Code 0111 executes when V=0.
- R6: Code 1000 (unsigned higher) executes when C=1 and Z=0. Code 1001 (unsigned lower-or-same) executes when C=0 or Z=1.
- R7: Code 1010 (signed greater-or-equal) executes when N equals V. Code 1011 (signed less-than) executes when N differs from V.
- R8: Code 1100 (signed greater-than) executes when Z=0 and N equals V. Code 1101 (signed less-or-equal) executes when Z=1 or N differs from V.
- R9: Code 1110 executes for every flag value.
- R10: Code 1111 never executes and always drives `reserved_o` high.
- R11: `reserved_o` is low for every code other than 1111.
- R12: Flags map as `flags_i[3]`=N, `flags_i[2]`=Z, `flags_i[1]`=C and `flags_i[0]`=V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word. The condition field is in bits 31:28. |
| flags_i | input | 4 | Status flags, packed as {N, Z, C, V}. |
| exec_o | output | 1 | High when the instruction's condition holds. |
| reserved_o | output | 1 | High when the field holds the reserved code 1111. |

## Verification
The assertions assume that `instr_i` and `flags_i` are fully known (no X or Z bits). With that assumption, each code maps to exactly one predicate. The assertions are immediate checks that are re-evaluated whenever an input changes, because the block holds no state. The stimulus drives only defined values. Inputs change on the falling clock edge and outputs are sampled on the rising edge, so every check sees settled values. The stimulus covers all 256 combinations of code and flags, with random bits below the field, and then repeats each code with its lower bits flipped.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;

  localparam int unsigned COND_W  = 4;
  localparam int unsigned FLAG_W  = 4;
  localparam int unsigned BASE_N  = 1 << (COND_W - 1);
  localparam int unsigned SEL_W   = COND_W - 1;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_code_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } flags_t;

  // signed compare result "a >= b" after a subtract sets the flags
  function automatic logic f_signed_ge(flags_t f);
    return ~(f.neg ^ f.ovf);
  endfunction

  // unsigned compare result "a > b"
  function automatic logic f_unsigned_hi(flags_t f);
    return f.carry & ~f.zero;
  endfunction

  // predicate of the even code in pair number sel
  function automatic logic f_base_pred(logic [SEL_W-1:0] sel, flags_t f);
    logic r;
    case (sel)
      3'd0:    r = f.zero;
      3'd1:    r = f.carry;
      3'd2:    r = f.neg;
      3'd3:    r = f.ovf;
      3'd4:    r = f_unsigned_hi(f);
      3'd5:    r = f_signed_ge(f);
      3'd6:    r = ~f.zero & f_signed_ge(f);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cond_field_slice.sv
module cond_field_slice #(
  parameter int unsigned INSTR_W  = 32,
  parameter int unsigned COND_W   = 4,
  localparam int unsigned COND_LSB = INSTR_W - COND_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [COND_W-1:0]  cond_o
);
  assign cond_o = instr_i[INSTR_W-1:COND_LSB];

  // the bits below the field play no part in the decision
  logic unused_low;
  assign unused_low = ^instr_i[COND_LSB-1:0];
endmodule

// File: rtl/cond_base_bank.sv
module cond_base_bank
  import cond_gate_pkg::*;
(
  input  flags_t            flags_i,
  output logic [BASE_N-1:0] pred_vec_o
);
  for (genvar g = 0; g < BASE_N; g++) begin : g_lane
    assign pred_vec_o[g] = f_base_pred(SEL_W'(g), flags_i);
  end
endmodule

// File: rtl/cond_resolve.sv
module cond_resolve
  import cond_gate_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [BASE_N-1:0] pred_vec_i,
  output logic              base_hit_o,
  output logic              exec_o,
  output logic              reserved_o
);
  logic [SEL_W-1:0] pair_sel;
  logic             invert;

  assign pair_sel   = cond_i[COND_W-1:1];
  assign invert     = cond_i[0];
  assign base_hit_o = pred_vec_i[pair_sel];
  // the always-true lane inverted gives the never-execute code
  assign exec_o     = base_hit_o ^ invert;
  assign reserved_o = (cond_code_e'(cond_i) == CC_NV);
endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cond_gate_pkg::*;
(
  input  logic [31:0]       instr_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              exec_o,
  output logic              reserved_o
);
  localparam int unsigned INSTR_W = 32;

  logic [COND_W-1:0] cond_code;
  logic [BASE_N-1:0] pred_vec;
  logic              base_hit;
  flags_t            flags_s;

  assign flags_s = flags_t'(flags_i);

  cond_field_slice #(.INSTR_W(INSTR_W), .COND_W(COND_W)) slice_i (
    .instr_i (instr_i),
    .cond_o  (cond_code)
  );

  cond_base_bank bank_i (
    .flags_i    (flags_s),
    .pred_vec_o (pred_vec)
  );

  cond_resolve resolve_i (
    .cond_i     (cond_code),
    .pred_vec_i (pred_vec),
    .base_hit_o (base_hit),
    .exec_o     (exec_o),
    .reserved_o (reserved_o)
  );
endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk (
  input logic [31:0] instr_i,
  input logic [3:0]  flags_i,
  input logic        exec_o,
  input logic        reserved_o,
  input logic [3:0]  cond_code,
  input logic        base_hit
);
  logic n, z, c, v;
  assign n = flags_i[3];
  assign z = flags_i[2];
  assign c = flags_i[1];
  assign v = flags_i[0];

  always_comb begin
    // R1: slice carries the top nibble
    a_r1_field_top: assert (cond_code == instr_i[31:28]) else $error("a_r1_field_top");
    // R2
    if (instr_i[31:28] == 4'h0)
      a_r2_eq: assert (exec_o == z) else $error("a_r2_eq");
    // R6
    if (instr_i[31:28] == 4'h9)
      a_r6_ls: assert (exec_o == (!c || z)) else $error("a_r6_ls");
    // R7
    if (instr_i[31:28] == 4'hB)
      a_r7_lt: assert (exec_o == (n != v)) else $error("a_r7_lt");
    // R8
    if (instr_i[31:28] == 4'hC)
      a_r8_gt: assert (exec_o == (!z && n == v)) else $error("a_r8_gt");
    // R9
    if (instr_i[31:28] == 4'hE)
      a_r9_always: assert (exec_o && base_hit) else $error("a_r9_always");
    // R10
    if (instr_i[31:28] == 4'hF)
      a_r10_never: assert (!exec_o && reserved_o) else $error("a_r10_never");
    // R11
    if (reserved_o)
      a_r11_only_nv: assert (instr_i[31:28] == 4'hF) else $error("a_r11_only_nv");
    // R3..R5 pairing: odd code is the complement of the even lane
    a_r3_pair_polarity: assert (exec_o == (base_hit ^ instr_i[28])) else $error("a_r3_pair_polarity");
  end
endmodule

bind cond_gate cond_gate_chk chk_i (
  .instr_i    (instr_i),
  .flags_i    (flags_i),
  .exec_o     (exec_o),
  .reserved_o (reserved_o),
  .cond_code  (cond_code),
  .base_hit   (base_hit)
);

// File: tb/cond_gate_tb_top.sv
module cond_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic [3:0]  flags_i = '0;
  logic        exec_o, reserved_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic exec;
    logic rsv;
    int   req;
    logic [3:0] code;
    logic [3:0] flg;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_gate dut_i (
    .instr_i    (instr_i),
    .flags_i    (flags_i),
    .exec_o     (exec_o),
    .reserved_o (reserved_o)
  );

  function automatic logic model(input logic [3:0] code, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (code)
      4'h0: return z;                     // R2
      4'h1: return !z;                    // R2
      4'h2: return c;                     // R3
      4'h3: return !c;                    // R3
      4'h4: return n;                     // R4
      4'h5: return !n;                    // R4
      4'h6: return v;                     // R5
      4'h7: return !v;                    // R5
      4'h8: return c && !z;               // R6
      4'h9: return !c || z;               // R6
      4'hA: return n == v;                // R7
      4'hB: return n != v;                // R7
      4'hC: return !z && (n == v);        // R8
      4'hD: return z || (n != v);         // R8
      4'hE: return 1'b1;                  // R9
      default: return 1'b0;               // R10
    endcase
  endfunction

  function automatic int req_of(input logic [3:0] code);
    case (code[3:1])
      3'd0: return 2;
      3'd1: return 3;
      3'd2: return 4;
      3'd3: return 5;
      3'd4: return 6;
      3'd5: return 7;
      3'd6: return 8;
      default: return code[0] ? 10 : 9;
    endcase
  endfunction

  task automatic drive(input logic [3:0] code, input logic [3:0] f, input logic [27:0] low, input int req);
    exp_t e;
    @(negedge clk);
    instr_i = {code, low};
    flags_i = f;
    e.exec = model(code, f);
    e.rsv  = (code == 4'hF);          // R10 R11
    e.req  = req;
    e.code = code;
    e.flg  = f;
    sb_q.push_back(e);
  endtask

  // monitor: pops one expectation per rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (exec_o !== e.exec) begin
          failures++;
          $display("FAIL R%0d exec code=%h flags=%b actual=%b expected=%b", e.req, e.code, e.flg, exec_o, e.exec);
        end
        checks++;
        if (reserved_o !== e.rsv) begin
          failures++;
          $display("FAIL R11 reserved code=%h flags=%b actual=%b expected=%b", e.code, e.flg, reserved_o, e.rsv);
        end
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    // reset state: code EQ, all flags clear => no execute, no reserved (R2)
    #1;
    checks++;
    if (exec_o !== 1'b0 || reserved_o !== 1'b0) begin
      failures++;
      $display("FAIL R2 reset exec/rsv actual=%b%b expected=00", exec_o, reserved_o);
    end
    rst_n = 1'b1;
    // exhaustive code x flag sweep with random low bits (R2..R12)
    for (int k = 0; k < 16; k++) begin
      for (int f = 0; f < 16; f++) begin
        drive(4'(k), 4'(f), 28'($urandom), req_of(4'(k)));
      end
    end
    // R1: low bits all ones then all zeros for each code
    for (int k = 0; k < 16; k++) begin
      drive(4'(k), 4'b1010, 28'hFFFFFFF, 1);   // R1
      drive(4'(k), 4'b1010, 28'h0000000, 1);   // R1
    end
    // R12: single flags in isolation against their own codes
    drive(4'h4, 4'b1000, 28'h1234567, 12);
    drive(4'h0, 4'b0100, 28'h1234567, 12);
    drive(4'h2, 4'b0010, 28'h1234567, 12);
    drive(4'h6, 4'b0001, 28'h1234567, 12);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule